// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block holds the interrupt priority state of one hardware thread. The state is split into four privilege rings: user, OS, pool and physical. Each ring keeps three values. The first is an 8-bit pending buffer with one bit per priority level. The second is the most favoured pending priority, derived from that buffer. The third is a current processor priority that software sets. Eight levels are valid, numbered 0 to 7, and 0 is the most favoured. The code 0xFF stands for "nothing pending" and is also the least favoured value.

A presenter posts requests, each one naming a ring and a priority. The block compares each ring's best pending priority with its current priority. From that comparison it drives two exception lines: one toward the hypervisor and one toward the OS. Software reaches the ring registers through a four-page window, where the page number sets the privilege of the access. Software can set the current priority, overwrite the pending buffer, read the derived priority, or acknowledge the best pending interrupt in a single read.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset every pending buffer is zero, every current priority is 0 and every pending priority reads 0xFF. Both exception outputs are low.
- R2: A request with priority p in 0..7 sets bit (7 - p) of the pending buffer of the named ring (ring code 0 user, 1 OS, 2 pool, 3 physical). The buffer can be read in the cycle that follows the request.
- R3: A request with priority 8 or above changes no pending buffer.
- R4: The pending priority of a ring equals the count of leading zeros of its 8-bit pending buffer, counted from bit 7. It is 0xFF when the buffer is empty.
- R5: A ring requests an exception while its pending priority is strictly below its current priority. The OS ring drives osIrq. The pool and physical rings together drive hvIrq. The user ring drives neither output.
- R6: An acknowledge read returns the ring's pending priority. If that value is not 0xFF, the read clears its bit and loads it into the current priority. If it is 0xFF, no state changes.
- R7: Register select codes are: 0 current priority (read/write), 1 pending buffer (read/write), 2 pending priority (read-only), 3 acknowledge (read). Writes to codes 2 and 3 have no effect.
- R8: An access from page g to ring r is allowed only when r + g <= 3. Page 0 is hardware, 1 hypervisor, 2 OS and 3 user. A disallowed write has no effect, a disallowed read returns 0, and a disallowed acknowledge changes nothing.
- R9: Read data appears on busRdata with busRvalid high in the cycle after a read. busRvalid stays low after writes and idle cycles.
- R10: When a request and a pending-buffer write or an acknowledge hit the same ring in the same cycle, the write or clear is applied first and the request bit is then added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Presenter request strobe |
| reqRing | input | 2 | Ring targeted by the request |
| reqPrio | input | 8 | Priority of the request |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 write, 0 read |
| busPage | input | 2 | Access page (privilege) |
| busRing | input | 2 | Ring being accessed |
| busReg | input | 2 | Register select |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, one cycle after the read |
| busRvalid | output | 1 | Read data valid |
| hvIrq | output | 1 | Exception toward the hypervisor |
| osIrq | output | 1 | Exception toward the OS |

## Verification
The bench builds the block with its default values: four rings and eight priority levels on an 8-bit data path. With these values every ring and page pairing is reachable, including both edges of the privilege rule (r + g = 3 and r + g = 4). The same defaults put both ends of the priority range within reach: level 0, level 7, out-of-range 9, and the empty-buffer code 0xFF returned by an acknowledge. They also let the bench run a same-cycle acknowledge and request on one ring.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int RING_CNT = 4;
  localparam int PRIO_CNT = 8;
  localparam int DATA_W   = 8;
  localparam int RING_W   = $clog2(RING_CNT);
  localparam int REG_W    = 2;
  localparam logic [DATA_W-1:0] PRIO_NONE = '1;

  localparam int RING_USER = 0;
  localparam int RING_OS   = 1;
  localparam int RING_POOL = 2;
  localparam int RING_PHYS = 3;

  typedef enum logic [REG_W-1:0] {
    REG_CUR  = 2'd0,
    REG_PEND = 2'd1,
    REG_BEST = 2'd2,
    REG_ACK  = 2'd3
  } tic_reg_e;

  typedef struct packed {
    logic [RING_CNT-1:0] wrCur;
    logic [RING_CNT-1:0] wrPend;
    logic [RING_CNT-1:0] ackClr;
    logic [RING_CNT-1:0] reqSet;
    logic [PRIO_CNT-1:0] reqMask;
    logic [DATA_W-1:0]   wdata;
  } tic_strb_t;

  // One-hot pending bit for a priority; zero for out-of-range levels.
  function automatic logic [PRIO_CNT-1:0] prioToMask(input logic [DATA_W-1:0] prio);
    logic [PRIO_CNT-1:0] m;
    m = '0;
    for (int i = 0; i < PRIO_CNT; i++)
      if (prio == DATA_W'(i)) m[PRIO_CNT-1-i] = 1'b1;
    return m;
  endfunction

  // Leading-zero count of the pending buffer, or the none code.
  function automatic logic [DATA_W-1:0] prioFromPend(input logic [PRIO_CNT-1:0] pend);
    logic [DATA_W-1:0] res;
    res = PRIO_NONE;
    for (int i = PRIO_CNT-1; i >= 0; i--)
      if (pend[PRIO_CNT-1-i]) res = DATA_W'(i);
    return res;
  endfunction
endpackage

// File: rtl/tic_ring_dp.sv
module tic_ring_dp
  import tic_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tic_strb_t           strb,
  output logic [DATA_W-1:0]   curPrio  [RING_CNT],
  output logic [PRIO_CNT-1:0] pendBuf  [RING_CNT],
  output logic [DATA_W-1:0]   bestPrio [RING_CNT],
  output logic [RING_CNT-1:0] excReq
);
  for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
    logic [PRIO_CNT-1:0] pendQ, pendNext;
    logic [DATA_W-1:0]   curQ, best;
    logic                ackHit;

    assign best   = prioFromPend(pendQ);
    assign ackHit = strb.ackClr[r] && (best != PRIO_NONE);

    always_comb begin
      pendNext = pendQ;
      if (strb.wrPend[r])
        pendNext = strb.wdata[PRIO_CNT-1:0];
      else if (strb.ackClr[r])
        pendNext = pendQ & ~prioToMask(best);
      if (strb.reqSet[r])
        pendNext = pendNext | strb.reqMask;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= '0;
        curQ  <= '0;
      end else begin
        pendQ <= pendNext;
        if (strb.wrCur[r])
          curQ <= strb.wdata;
        else if (ackHit)
          curQ <= best;
      end
    end

    assign curPrio[r]  = curQ;
    assign pendBuf[r]  = pendQ;
    assign bestPrio[r] = best;
    assign excReq[r]   = best < curQ;
  end
endmodule

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [RING_W-1:0]   reqRing,
  input  logic [DATA_W-1:0]   reqPrio,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [1:0]          busPage,
  input  logic [RING_W-1:0]   busRing,
  input  logic [REG_W-1:0]    busReg,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   curPrio  [RING_CNT],
  input  logic [PRIO_CNT-1:0] pendBuf  [RING_CNT],
  input  logic [DATA_W-1:0]   bestPrio [RING_CNT],
  output tic_strb_t           strb,
  output logic [DATA_W-1:0]   busRdata,
  output logic                busRvalid
);
  logic              allowed, isRd, isWr;
  tic_reg_e          regSel;
  logic [DATA_W-1:0] rdNext, rdataQ;
  logic              rvalidQ;

  // Less privileged pages see fewer rings.
  assign allowed = (int'(busRing) + int'(busPage)) <= (RING_CNT - 1);
  assign isRd    = busValid && !busWrite;
  assign isWr    = busValid && busWrite;
  assign regSel  = tic_reg_e'(busReg);

  always_comb begin
    strb         = '0;
    strb.wdata   = busWdata;
    strb.reqMask = prioToMask(reqPrio);
    strb.reqSet[reqRing] = reqValid;
    if (allowed) begin
      strb.wrCur[busRing]  = isWr && (regSel == REG_CUR);
      strb.wrPend[busRing] = isWr && (regSel == REG_PEND);
      strb.ackClr[busRing] = isRd && (regSel == REG_ACK);
    end
  end

  always_comb begin
    rdNext = '0;
    if (allowed) begin
      unique case (regSel)
        REG_CUR:  rdNext = curPrio[busRing];
        REG_PEND: rdNext = DATA_W'(pendBuf[busRing]);
        REG_BEST: rdNext = bestPrio[busRing];
        REG_ACK:  rdNext = bestPrio[busRing];
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
    end else begin
      rvalidQ <= isRd;
      if (isRd) rdataQ <= rdNext;
    end
  end

  assign busRdata  = rdataQ;
  assign busRvalid = rvalidQ;
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx
  import tic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RING_W-1:0] reqRing,
  input  logic [DATA_W-1:0] reqPrio,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busPage,
  input  logic [RING_W-1:0] busRing,
  input  logic [REG_W-1:0]  busReg,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              hvIrq,
  output logic              osIrq
);
  tic_strb_t           strb;
  logic [DATA_W-1:0]   curPrio  [RING_CNT];
  logic [PRIO_CNT-1:0] pendBuf  [RING_CNT];
  logic [DATA_W-1:0]   bestPrio [RING_CNT];
  logic [RING_CNT-1:0] excReq;

  tic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqRing(reqRing), .reqPrio(reqPrio),
    .busValid(busValid), .busWrite(busWrite), .busPage(busPage),
    .busRing(busRing), .busReg(busReg), .busWdata(busWdata),
    .curPrio(curPrio), .pendBuf(pendBuf), .bestPrio(bestPrio),
    .strb(strb), .busRdata(busRdata), .busRvalid(busRvalid)
  );

  tic_ring_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .curPrio(curPrio), .pendBuf(pendBuf), .bestPrio(bestPrio),
    .excReq(excReq)
  );

  assign osIrq = excReq[RING_OS];
  assign hvIrq = excReq[RING_POOL] | excReq[RING_PHYS];
endmodule

// File: rtl/tic_checker.sv
module tic_checker
  import tic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [RING_W-1:0] reqRing,
  input logic [DATA_W-1:0] reqPrio,
  input logic              busValid,
  input logic              busWrite,
  input logic [1:0]        busPage,
  input logic [RING_W-1:0] busRing,
  input logic [REG_W-1:0]  busReg,
  input logic [DATA_W-1:0] busRdata,
  input logic              busRvalid,
  input logic              hvIrq,
  input logic              osIrq
);
  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> busRvalid);

  a_r9_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !busRvalid);

  a_r8_denied_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (int'(busRing) + int'(busPage) > RING_CNT - 1))
      |=> (busRdata == '0));

  a_r6_ack_drops_os: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busReg == REG_ACK && busRing == RING_OS
     && busPage <= 2'd2 && !reqValid) |=> !osIrq);

  a_r3_bad_prio_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPrio >= PRIO_CNT && !busValid && !osIrq) |=> !osIrq);

  a_r5_user_ring_no_hv: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqRing == RING_USER && !busValid && !hvIrq) |=> !hvIrq);

  a_r4_best_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (busRvalid && $past(busValid && !busWrite && busReg == REG_BEST))
      |-> (busRdata < PRIO_CNT || busRdata == PRIO_NONE));
endmodule

bind thread_irq_ctx tic_checker u_tic_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRing(reqRing),
  .reqPrio(reqPrio), .busValid(busValid), .busWrite(busWrite),
  .busPage(busPage), .busRing(busRing), .busReg(busReg),
  .busRdata(busRdata), .busRvalid(busRvalid), .hvIrq(hvIrq), .osIrq(osIrq)
);

// File: tb/thread_irq_ctx_bench.sv
`timescale 1ns/1ps
module thread_irq_ctx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqRing = '0;
  logic [7:0] reqPrio = '0;
  logic       busValid = 1'b0;
  logic       busWrite = 1'b0;
  logic [1:0] busPage = '0;
  logic [1:0] busRing = '0;
  logic [1:0] busReg = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busRvalid;
  logic       hvIrq, osIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] mPend[4];
  logic [7:0] mCur[4];

  always #2 clk = ~clk;

  thread_irq_ctx u_thread_irq_ctx (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRing(reqRing),
    .reqPrio(reqPrio), .busValid(busValid), .busWrite(busWrite),
    .busPage(busPage), .busRing(busRing), .busReg(busReg),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .hvIrq(hvIrq), .osIrq(osIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mBest(input int r);
    for (int i = 0; i < 8; i++)
      if (mPend[r][7-i]) return 8'(i);
    return 8'hFF;
  endfunction

  // Monitor: pops one expected value per returned read.
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) check(1'b0, "R9 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdata == e, t, busRdata, e);
      end
    end
  end

  // Driver: one cycle of stimulus, model update, then output check.
  task automatic step(input bit rv, input int rr, input int rp,
                      input bit bv, input bit bw, input int pg, input int rg,
                      input int rs, input int wd, input string tag);
    bit ok;
    logic [7:0] best, rd;
    reqValid = rv; reqRing = 2'(rr); reqPrio = 8'(rp);
    busValid = bv; busWrite = bw; busPage = 2'(pg); busRing = 2'(rg);
    busReg = 2'(rs); busWdata = 8'(wd);
    ok = (rg + pg) <= 3;
    best = mBest(rg);
    if (bv && !bw) begin
      rd = 8'h00;
      if (ok) case (rs)
        0: rd = mCur[rg];
        1: rd = mPend[rg];
        default: rd = best;
      endcase
      expQ.push_back(rd);
      tagQ.push_back(tag);
    end
    if (bv && ok) begin
      if (bw && rs == 0) mCur[rg] = 8'(wd);
      if (bw && rs == 1) mPend[rg] = 8'(wd);
      if (!bw && rs == 3 && best != 8'hFF) begin
        mPend[rg][7 - best] = 1'b0;
        mCur[rg] = best;
      end
    end
    if (rv && rp < 8) mPend[rr][7 - rp] = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    busValid = 1'b0;
    check(osIrq == (mBest(1) < mCur[1]), {tag, " R5 osIrq"}, osIrq, mBest(1) < mCur[1]);
    check(hvIrq == ((mBest(2) < mCur[2]) || (mBest(3) < mCur[3])),
          {tag, " R5 hvIrq"}, hvIrq, (mBest(2) < mCur[2]) || (mBest(3) < mCur[3]));
  endtask

  task automatic rd(input int pg, input int rg, input int rs, input string tag);
    step(0, 0, 0, 1, 0, pg, rg, rs, 0, tag);
  endtask
  task automatic wr(input int pg, input int rg, input int rs, input int wd, input string tag);
    step(0, 0, 0, 1, 1, pg, rg, rs, wd, tag);
  endtask
  task automatic rq(input int rr, input int rp, input string tag);
    step(1, rr, rp, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) begin mPend[r] = '0; mCur[r] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!osIrq && !hvIrq, "R1 outputs low", {osIrq, hvIrq}, 0);
    for (int r = 0; r < 4; r++) begin
      rd(0, r, 2, "R1 best reads none");
      rd(0, r, 0, "R1 current is zero");
      rd(0, r, 1, "R1 pending empty");
    end
    // R2/R4: OS ring request, masked by current 0
    rq(1, 3, "R2 req os p3");
    rd(0, 1, 1, "R2 pend bit4");
    rd(0, 1, 2, "R4 best is 3");
    wr(2, 1, 0, 8'hFF, "R5 unmask os");
    rq(1, 5, "R2 req os p5");
    rd(2, 1, 1, "R2 pend two bits");
    rq(1, 9, "R3 out of range");
    rd(2, 1, 1, "R3 pend unchanged");
    // R6: acknowledge sequence down to empty
    rd(2, 1, 3, "R6 ack returns 3");
    rd(2, 1, 0, "R6 current loaded");
    rd(2, 1, 3, "R6 ack returns 5");
    rd(2, 1, 3, "R6 ack empty none");
    rd(2, 1, 0, "R6 current kept");
    // pool ring and hv output
    rq(2, 0, "R2 req pool p0");
    wr(1, 2, 0, 1, "R5 unmask pool");
    wr(1, 2, 2, 8'h55, "R7 write best ignored");
    wr(1, 2, 3, 8'h55, "R7 write ack ignored");
    rd(1, 2, 1, "R7 pool pend intact");
    // R8 privilege
    rd(2, 2, 0, "R8 os page pool read zero");
    rd(2, 2, 3, "R8 os page ack denied");
    rd(0, 2, 1, "R8 pool pend after denied ack");
    wr(3, 1, 0, 0, "R8 user page write ignored");
    rd(3, 1, 0, "R8 user page os read zero");
    rd(0, 1, 0, "R8 os current intact");
    rd(0, 3, 2, "R8 hw page phys read");
    // user ring raises nothing
    wr(3, 0, 0, 8'hFF, "R5 user unmask");
    rq(0, 0, "R5 user req");
    rd(3, 0, 2, "R4 user best 0");
    // R7 pending write, boundary level 7
    wr(0, 3, 1, 8'h01, "R7 write phys pend");
    rd(0, 3, 2, "R4 best is 7");
    wr(0, 3, 0, 8, "R5 phys current 8");
    // R10 same-cycle ack and request on pool
    step(1, 2, 2, 1, 0, 0, 2, 3, 0, "R10 ack with req");
    rd(0, 2, 1, "R10 pool pend");
    rd(0, 2, 0, "R10 pool current");
    step(1, 3, 0, 1, 1, 0, 3, 1, 8'h02, "R10 write with req");
    rd(0, 3, 1, "R10 phys pend");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9 all reads returned", expQ.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule